// File: doc/BRIEF.md
# 10BASE-T Receive Polarity Corrector

This block decides whether the receive twisted pair of a 10BASE-T port has been wired with its two conductors swapped, and drives a control that flips the recovered serial data when it has. The line front end and the Manchester decoder sit outside it. They hand the block qualified single-cycle strobes: a link pulse seen in normal polarity, a link pulse seen inverted, an end-of-frame marker seen in normal polarity, an end-of-frame marker seen inverted, and a general receive-activity strobe. A free-running millisecond tick drives the silence timer. Every polarity strobe describes the raw, uncorrected line.

Two separate run counters track unbroken sequences of events whose polarity disagrees with the current decision. One counts link pulses and the other counts end-of-frame markers. When either run reaches its threshold, the decision flips and both runs start again from zero. A silence timer counts millisecond ticks since the last receive event of any kind. When it expires, the decision returns to normal. The decision is presented both as a status bit and as the data-invert control.

Top module: `rxpol_corrector`

## Requirements
- R1: From the normal state, LP_RUN (default 8) inverted link pulse strobes with no normal link pulse strobe between them set `pol_inverted_o` in the cycle after the last of them. Fewer than LP_RUN leave it clear.
- R2: From the normal state, EOF_RUN (default 4) inverted end-of-frame strobes with no normal end-of-frame strobe between them set `pol_inverted_o` in the cycle after the last of them. Fewer than EOF_RUN leave it clear.
- R3: An event whose polarity agrees with the current decision clears the run for its own type. Only an unbroken run of disagreeing events of one type reaches the threshold.
- R4: An event of one type does not break the run of the other type.
- R5: Events that agree with the current decision never change it, however many arrive.
- R6: While inverted, LP_RUN normal link pulses in a row, or EOF_RUN normal end-of-frame markers in a row, return the decision to normal.
- R7: A flip clears both runs, so a partial run collected before the flip does not count afterwards.
- R8: TIMEOUT_MS (default 100, legal range 96 to 128) millisecond ticks in a row with no receive strobe of any kind return the decision to normal in the cycle after the last tick. Any strobe, including plain receive activity, restarts the count.
- R9: A synchronous reset clears both runs and the silence count, and leaves the block in the normal state.
- R10: `rx_invert_o` equals `pol_inverted_o` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lp_norm_i | input | 1 | Link pulse seen with normal polarity |
| lp_inv_i | input | 1 | Link pulse seen with inverted polarity |
| eof_norm_i | input | 1 | End-of-frame marker seen with normal polarity |
| eof_inv_i | input | 1 | End-of-frame marker seen with inverted polarity |
| rx_act_i | input | 1 | Any other receive activity |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| pol_inverted_o | output | 1 | Status: reversed polarity detected |
| rx_invert_o | output | 1 | Control: invert the received serial data |

## Verification
The hardest situation to reach is a run counter holding stale progress at the moment the decision flips. If that progress survived the flip, the next event of that type would count toward flipping back. The stimulus builds a partial end-of-frame run, completes a link-pulse run to force the flip, and then sends a single end-of-frame marker that disagrees with the new decision. The state must hold. Runs interrupted at every possible position are also swept, and the silence timer is driven exactly to one tick short of expiry, restarted, and driven again.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;

  typedef enum logic {
    POL_NORMAL   = 1'b0,
    POL_INVERTED = 1'b1
  } pol_e;

  // Toggle the polarity decision.
  function automatic pol_e pol_other(input pol_e p);
    return (p == POL_NORMAL) ? POL_INVERTED : POL_NORMAL;
  endfunction

endpackage

// File: rtl/rxpol_run_counter.sv
module rxpol_run_counter #(
  parameter int unsigned THRESH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic hit_i,
  input  logic miss_i,
  output logic reached_o
);
  localparam int unsigned W = $clog2(THRESH + 1);
  localparam logic [W-1:0] LAST = W'(THRESH - 1);

  logic [W-1:0] cnt_q;

  // Next run length: a miss breaks the run, a hit extends it.
  function automatic logic [W-1:0] run_next(input logic [W-1:0] c,
                                            input logic h, input logic m);
    if (m)      return '0;
    else if (h) return (c == LAST) ? '0 : c + 1'b1;
    else        return c;
  endfunction

  assign reached_o = hit_i && !miss_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else              cnt_q <= run_next(cnt_q, hit_i, miss_i);
  end

  assert_run_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q < W'(THRESH));

endmodule

// File: rtl/rxpol_quiet_timer.sv
module rxpol_quiet_timer #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic activity_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  function automatic logic [W-1:0] quiet_next(input logic [W-1:0] c,
                                              input logic act, input logic t);
    if (act)    return '0;
    else if (t) return (c == LAST) ? '0 : c + 1'b1;
    else        return c;
  endfunction

  assign expire_o = tick_i && !activity_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= quiet_next(cnt_q, activity_i, tick_i);
  end

  assert_quiet_bounded_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q < W'(LIMIT));

endmodule

// File: rtl/rxpol_corrector.sv
module rxpol_corrector #(
  parameter int unsigned LP_RUN     = 8,
  parameter int unsigned EOF_RUN    = 4,
  parameter int unsigned TIMEOUT_MS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic lp_norm_i,
  input  logic lp_inv_i,
  input  logic eof_norm_i,
  input  logic eof_inv_i,
  input  logic rx_act_i,
  input  logic ms_tick_i,
  output logic pol_inverted_o,
  output logic rx_invert_o
);
  import rxpol_pkg::*;

  pol_e state_q;

  // Named internal events.
  logic lp_hit, lp_miss, eof_hit, eof_miss;
  logic lp_reach, eof_reach, flip, expire, any_event, run_clr;

  // A hit disagrees with the current decision, a miss agrees with it.
  assign lp_hit    = (state_q == POL_NORMAL) ? lp_inv_i   : lp_norm_i;
  assign lp_miss   = (state_q == POL_NORMAL) ? lp_norm_i  : lp_inv_i;
  assign eof_hit   = (state_q == POL_NORMAL) ? eof_inv_i  : eof_norm_i;
  assign eof_miss  = (state_q == POL_NORMAL) ? eof_norm_i : eof_inv_i;
  assign any_event = lp_norm_i | lp_inv_i | eof_norm_i | eof_inv_i | rx_act_i;
  assign flip      = lp_reach | eof_reach;
  assign run_clr   = flip | expire;

  rxpol_run_counter #(.THRESH(LP_RUN)) u_lp_run (
    .clk(clk), .rst(rst), .clr_i(run_clr),
    .hit_i(lp_hit), .miss_i(lp_miss), .reached_o(lp_reach));

  rxpol_run_counter #(.THRESH(EOF_RUN)) u_eof_run (
    .clk(clk), .rst(rst), .clr_i(run_clr),
    .hit_i(eof_hit), .miss_i(eof_miss), .reached_o(eof_reach));

  rxpol_quiet_timer #(.LIMIT(TIMEOUT_MS)) u_quiet (
    .clk(clk), .rst(rst), .activity_i(any_event),
    .tick_i(ms_tick_i), .expire_o(expire));

  always_ff @(posedge clk) begin
    if (rst)         state_q <= POL_NORMAL;
    else if (expire) state_q <= POL_NORMAL;
    else if (flip)   state_q <= pol_other(state_q);
  end

  assign pol_inverted_o = (state_q == POL_INVERTED);
  assign rx_invert_o    = (state_q == POL_INVERTED);

  assert_flip_needs_run_R1: assert property (@(posedge clk) disable iff (rst)
    (state_q != $past(state_q)) |-> ($past(lp_reach) || $past(eof_reach) || $past(expire)));

  assert_timeout_normal_R8: assert property (@(posedge clk) disable iff (rst)
    expire |=> (state_q == POL_NORMAL));

  assert_event_blocks_timeout_R8: assert property (@(posedge clk) disable iff (rst)
    any_event |-> !expire);

  assert_reset_normal_R9: assert property (@(posedge clk)
    rst |=> (state_q == POL_NORMAL));

endmodule

// File: tb/rxpol_corrector_tb.sv
module rxpol_corrector_tb;
  localparam int LP_N  = 8;
  localparam int EOF_N = 4;
  localparam int TMO   = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lp_norm = 0, lp_inv = 0, eof_norm = 0, eof_inv = 0, rx_act = 0, tick = 0;
  logic pol_inv, rx_invert;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rxpol_corrector #(.LP_RUN(LP_N), .EOF_RUN(EOF_N), .TIMEOUT_MS(TMO)) u_dut (
    .clk(clk), .rst(rst), .lp_norm_i(lp_norm), .lp_inv_i(lp_inv),
    .eof_norm_i(eof_norm), .eof_inv_i(eof_inv), .rx_act_i(rx_act),
    .ms_tick_i(tick), .pol_inverted_o(pol_inv), .rx_invert_o(rx_invert));

  // kind: 0 link pulse, 1 end of frame, 2 activity, 3 tick; inv picks polarity
  task automatic ev(input int kind, input bit inv);
    @(negedge clk);
    case (kind)
      0: if (inv) lp_inv = 1; else lp_norm = 1;
      1: if (inv) eof_inv = 1; else eof_norm = 1;
      2: rx_act = 1;
      default: tick = 1;
    endcase
    @(negedge clk);
    lp_norm = 0; lp_inv = 0; eof_norm = 0; eof_inv = 0; rx_act = 0; tick = 0;
  endtask

  task automatic evn(input int kind, input bit inv, input int n);
    for (int i = 0; i < n; i++) ev(kind, inv);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  // Sampled at a falling edge; R10 is checked alongside every check.
  task automatic check(input string tag, input logic exp);
    tests++;
    if (pol_inv !== exp) begin
      fails++;
      $display("FAIL %s pol_inverted got=%0b exp=%0b", tag, pol_inv, exp);
    end
    tests++;
    if (rx_invert !== pol_inv) begin
      fails++;
      $display("FAIL R10 rx_invert got=%0b exp=%0b", rx_invert, pol_inv);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    check("R9 reset state", 1'b0);

    // R1: sweep the length of an inverted link pulse run
    for (int n = 0; n <= LP_N + 4; n++) begin
      do_reset();
      evn(0, 1, n);
      check("R1 lp run", (n >= LP_N));
    end

    // R2: sweep the length of an inverted end-of-frame run
    for (int n = 0; n <= EOF_N + 3; n++) begin
      do_reset();
      evn(1, 1, n);
      check("R2 eof run", (n >= EOF_N));
    end

    // R3: a normal event of the same type breaks the run at every position
    for (int k = 0; k < LP_N; k++) begin
      do_reset();
      evn(0, 1, k); ev(0, 0); evn(0, 1, LP_N - 1);
      check("R3 lp broken", 1'b0);
      ev(0, 1);
      check("R3 lp rerun", 1'b1);
    end
    for (int k = 0; k < EOF_N; k++) begin
      do_reset();
      evn(1, 1, k); ev(1, 0); evn(1, 1, EOF_N - 1);
      check("R3 eof broken", 1'b0);
      ev(1, 1);
      check("R3 eof rerun", 1'b1);
    end

    // R4: the other type does not break a run
    do_reset();
    evn(0, 1, LP_N - 1); ev(1, 0); ev(0, 1);
    check("R4 eof inside lp run", 1'b1);
    do_reset();
    evn(1, 1, EOF_N - 1); ev(0, 0); ev(2, 0); ev(1, 1);
    check("R4 lp inside eof run", 1'b1);

    // R5 and R6: agreeing events hold, a reverse run restores normal
    do_reset();
    evn(0, 1, LP_N);
    evn(0, 1, 2 * LP_N); evn(1, 1, 2 * EOF_N);
    check("R5 agreeing events", 1'b1);
    evn(0, 0, LP_N - 1);
    check("R6 lp short reverse", 1'b1);
    ev(0, 0);
    check("R6 lp reverse run", 1'b0);
    evn(0, 0, LP_N); evn(1, 0, EOF_N);
    check("R5 agreeing normal", 1'b0);
    evn(1, 1, EOF_N);
    evn(1, 0, EOF_N);
    check("R6 eof reverse run", 1'b0);

    // R7: a partial eof run must not survive a flip
    do_reset();
    evn(1, 1, EOF_N - 1);
    evn(0, 1, LP_N);
    ev(1, 0);
    check("R7 stale run cleared", 1'b1);

    // R8: silence timeout, restarted by activity and by polarity strobes
    do_reset();
    evn(0, 1, LP_N);
    evn(3, 0, TMO - 1);
    check("R8 before expiry", 1'b1);
    ev(2, 0);
    evn(3, 0, TMO - 1);
    check("R8 restart by activity", 1'b1);
    ev(0, 1);
    evn(3, 0, TMO - 1);
    check("R8 restart by link pulse", 1'b1);
    ev(3, 0);
    check("R8 expiry", 1'b0);

    // R9: reset mid-run and while inverted
    do_reset();
    evn(0, 1, LP_N - 3);
    do_reset();
    evn(0, 1, 3);
    check("R9 run cleared by reset", 1'b0);
    evn(0, 1, LP_N);
    check("R9 setup inverted", 1'b1);
    do_reset();
    check("R9 reset from inverted", 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule